// File: doc/BRIEF.md
# Cascadable Serial Display Data Register

This block receives display data one bit at a time and presents it as two parallel banks of segment bits, A and B, for a segment driver stage further down the chip. A serial bit enters the first stage of a shift chain on each rising edge of the shift clock. A load strobe controls a display latch. While the strobe is high the latch is transparent, so the banks follow the chain. While it is low the banks keep their last value, and the chain can be refilled without disturbing the display.

A mode input sets the active length of the chain. In static mode only the first bank of stages shifts. In half-duty mode both banks shift as one chain of twice that length. The bit at the end of the active chain is driven on a cascade output on the falling edge of the clock, so that a following device can sample it on its own rising edge. The clock and load strobe are also passed through unchanged for the next device in the chain. All logic runs in the shift clock's domain.

Top module: `serial_display_register`

## Requirements
- R1: On each rising clock edge out of reset, the `data_in` value is captured into stage 1, which is bank A bit 0, and every stage of the active chain takes the value of the stage before it.
- R2: `data_out` changes only on a falling clock edge. It keeps its value across the rising edge.
- R3: The cascade source is set by `mode_half`. With 0 (static), `data_out` takes stage SEGS (bank A bit SEGS-1). With 1 (half-duty), it takes stage 2*SEGS (bank B bit SEGS-1).
- R4: While `load_in` is 1, `bank_a` equals stages 1..SEGS and `bank_b` equals stages SEGS+1..2*SEGS of the chain.
- R5: While `load_in` is 0, both banks hold the values the chain had just before the strobe fell, whatever is shifted in meanwhile.
- R6: Stage n maps to bank A bit n-1, and stage SEGS+n maps to bank B bit n-1. The first bit shifted into a full static load therefore lands on bank A bit SEGS-1, and the first bit of a full half-duty load lands on bank B bit SEGS-1.
- R7: Bits are not inverted. A 1 shifted in appears as 1 (segment on) and a 0 appears as 0 (segment off).
- R8: `clk_out` equals `clk` and `load_out` equals `load_in` at all times.
- R9: In static mode, stages SEGS+1..2*SEGS keep their values on every clock edge, so `bank_b` does not change even while the latch is transparent.
- R10: A low `rst_n` sampled on a rising edge clears the whole chain and both banks. A low `rst_n` sampled on a falling edge clears `data_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, the only clock of the block |
| rst_n | input | 1 | Synchronous reset, active low |
| data_in | input | 1 | Serial display bit, highest segment first |
| load_in | input | 1 | Latch strobe: 1 = transparent, 0 = hold |
| mode_half | input | 1 | 0 = static (SEGS-stage chain), 1 = half-duty (2*SEGS-stage chain) |
| data_out | output | 1 | Cascade serial output, launched on the falling edge |
| clk_out | output | 1 | Pass-through copy of `clk` |
| load_out | output | 1 | Pass-through copy of `load_in` |
| bank_a | output | SEGS | Latched segment bits for the first common |
| bank_b | output | SEGS | Latched segment bits for the second common |

## Verification
A shift and a change of the latch strobe can fall in the same cycle. On the edge where the strobe is still high, the chain advances and the latch must show the new contents. After the strobe falls, the banks must freeze at exactly that content while shifting goes on. The bench provokes this by toggling the strobe in irregular bursts over a pseudo-random bit stream, and it changes the mode in the middle of these bursts. Every cycle it compares both banks and the cascade bit against a behavioural model of stages and latch. The cascade bit is compared both before and after each rising edge, so a launch on the wrong edge is caught.

// File: rtl/sdr_pkg.sv
// Shared types for the serial display data register.
// Assumes: a single clock domain, the shift clock.
package sdr_pkg;

    // Chain-length select; the encoding matches the mode_half pin.
    typedef enum logic {
        MODE_STATIC = 1'b0,
        MODE_HALF   = 1'b1
    } disp_mode_e;

    // Number of latch banks that the chain is split into.
    localparam int NUM_BANKS = 2;

endpackage

// File: rtl/sdr_shift_chain.sv
// Serial shift chain of NUM_BANKS*SEGS stages. Stage 1 is bit 0.
// The lower bank always shifts. The upper bank shifts only when half_en
// is set; otherwise it keeps its value.
// Assumes: synchronous active-low reset and a rising-edge capture.
module sdr_shift_chain
    import sdr_pkg::*;
#(
    parameter  int SEGS   = 160,
    localparam int STAGES = NUM_BANKS * SEGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_in,
    input  logic              half_en,
    output logic [STAGES-1:0] sr_d,
    output logic [STAGES-1:0] sr_q
);

    // Next-state of each bank; the parameter picks the variant per bank.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam int LO = g * SEGS;
        localparam int HI = LO + SEGS - 1;
        if (g == 0) begin : g_head
            assign sr_d[HI:LO] = {sr_q[HI-1:LO], data_in};
        end else begin : g_tail
            assign sr_d[HI:LO] = half_en ? {sr_q[HI-1:LO], sr_q[LO-1]}
                                         : sr_q[HI:LO];
        end
    end

    // Chain register: clears on reset, otherwise takes the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

endmodule

// File: rtl/sdr_bank_latch.sv
// Display latch for one bank. It is modelled synchronously: hold_q
// follows the chain on every edge with the strobe high, and the output
// is the live chain while the strobe is high and hold_q otherwise. This
// behaves like a level latch, but no storage element is level sensitive.
// Assumes: the chain only changes on rising edges.
module sdr_bank_latch #(
    parameter int W = 160
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d_next,
    input  logic [W-1:0] d_cur,
    output logic [W-1:0] q
);

    logic [W-1:0] hold_q;

    // Hold register: tracks the chain's next state while the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_q <= '0;
        else if (load) hold_q <= d_next;
    end

    // Output: transparent while loading, frozen otherwise.
    always_comb q = load ? d_cur : hold_q;

endmodule

// File: rtl/sdr_cascade_out.sv
// Cascade output stage. It launches the tail bit of the active chain on
// the falling clock edge, which gives the next device half a period of
// setup before its rising edge.
// Assumes: the reset input is stable around falling edges.
module sdr_cascade_out (
    input  logic clk,
    input  logic rst_n,
    input  logic half_en,
    input  logic tap_static,
    input  logic tap_half,
    output logic data_out
);

    // Falling-edge launch of the selected tail stage.
    always_ff @(negedge clk) begin
        if (!rst_n) data_out <= 1'b0;
        else        data_out <= half_en ? tap_half : tap_static;
    end

endmodule

// File: rtl/serial_display_register.sv
// Top level: serial chain, one display latch per bank, cascade output,
// and pass-through of clock and strobe for a following device.
// Assumes: everything runs in the shift clock domain; reset is
// synchronous and active low.
module serial_display_register
    import sdr_pkg::*;
#(
    parameter  int SEGS   = 160,
    localparam int STAGES = NUM_BANKS * SEGS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            data_in,
    input  logic            load_in,
    input  logic            mode_half,
    output logic            data_out,
    output logic            clk_out,
    output logic            load_out,
    output logic [SEGS-1:0] bank_a,
    output logic [SEGS-1:0] bank_b
);

    logic              half_en;
    logic [STAGES-1:0] sr_d;
    logic [STAGES-1:0] sr_q;
    logic [SEGS-1:0]   bank_w [NUM_BANKS];

    // Decode the mode pin against the shared encoding.
    always_comb half_en = (disp_mode_e'(mode_half) == MODE_HALF);

    sdr_shift_chain #(.SEGS(SEGS)) chain_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_in (data_in),
        .half_en (half_en),
        .sr_d    (sr_d),
        .sr_q    (sr_q)
    );

    // One latch per bank, each fed by its own slice of the chain.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_latch
        sdr_bank_latch #(.W(SEGS)) latch_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load_in),
            .d_next (sr_d[g*SEGS +: SEGS]),
            .d_cur  (sr_q[g*SEGS +: SEGS]),
            .q      (bank_w[g])
        );
    end

    sdr_cascade_out casc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_en    (half_en),
        .tap_static (sr_q[SEGS-1]),
        .tap_half   (sr_q[STAGES-1]),
        .data_out   (data_out)
    );

    // Bank outputs and pass-through buffers for the next device.
    assign bank_a   = bank_w[0];
    assign bank_b   = bank_w[1];
    assign clk_out  = clk;
    assign load_out = load_in;

endmodule

// File: rtl/serial_display_register_chk.sv
// Property checker for serial_display_register, attached with bind.
// Assumes: it sees the top's ports and its internal chain sr_q.
module serial_display_register_chk #(
    parameter  int SEGS   = 160,
    localparam int STAGES = 2 * SEGS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              data_in,
    input logic              load_in,
    input logic              mode_half,
    input logic              data_out,
    input logic [SEGS-1:0]   bank_a,
    input logic [SEGS-1:0]   bank_b,
    input logic [STAGES-1:0] sr_q
);

    // R1
    head_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sr_q[0] == $past(data_in)));

    // R1
    head_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sr_q[SEGS-1:1] == $past(sr_q[SEGS-2:0])));

    // R9
    tail_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_half |=> $stable(sr_q[STAGES-1:SEGS]));

    // R4
    transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_in |-> (bank_a == sr_q[SEGS-1:0] && bank_b == sr_q[STAGES-1:SEGS]));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_in && !$past(load_in)) |-> ($stable(bank_a) && $stable(bank_b)));

    // R3
    cascade_tap_chk: assert property (@(negedge clk) disable iff (!rst_n)
        1'b1 |=> (data_out == $past(mode_half ? sr_q[STAGES-1] : sr_q[SEGS-1])));

endmodule

bind serial_display_register serial_display_register_chk #(.SEGS(SEGS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_in   (data_in),
    .load_in   (load_in),
    .mode_half (mode_half),
    .data_out  (data_out),
    .bank_a    (bank_a),
    .bank_b    (bank_b),
    .sr_q      (sr_q)
);

// File: tb/serial_display_register_tb_top.sv
// Bench: a behavioural model of the stages and the latch, compared every
// cycle, plus directed checks of ordering, hold, freeze and reset.
module serial_display_register_tb_top;

    localparam int SEGS = 160;
    localparam int N2   = 2 * SEGS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic data_in = 1'b0;
    logic load_in = 1'b0;
    logic mode_half = 1'b0;
    logic data_out, clk_out, load_out;
    logic [SEGS-1:0] bank_a, bank_b;

    int total = 0;
    int bad = 0;
    bit running = 1'b0;

    // Behavioural model: one bit per stage (1-based) plus held banks.
    bit ref_stage [1:N2];
    bit ref_hold  [1:N2];
    bit ref_dout;

    serial_display_register #(.SEGS(SEGS)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_in   (data_in),
        .load_in   (load_in),
        .mode_half (mode_half),
        .data_out  (data_out),
        .clk_out   (clk_out),
        .load_out  (load_out),
        .bank_a    (bank_a),
        .bank_b    (bank_b)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [SEGS-1:0] act,
                         input logic [SEGS-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [SEGS-1:0] exp_bank(input int base);
        logic [SEGS-1:0] v;
        for (int i = 0; i < SEGS; i++)
            v[i] = load_in ? ref_stage[base+i+1] : ref_hold[base+i+1];
        return v;
    endfunction

    // Model update at the rising edge, using the inputs held over the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i <= N2; i++) begin
                ref_stage[i] = 1'b0;
                ref_hold[i]  = 1'b0;
            end
        end else begin
            if (mode_half)
                for (int i = N2; i > SEGS; i--) ref_stage[i] = ref_stage[i-1];
            for (int i = SEGS; i > 1; i--) ref_stage[i] = ref_stage[i-1];
            ref_stage[1] = data_in;
            if (load_in)
                for (int i = 1; i <= N2; i++) ref_hold[i] = ref_stage[i];
        end
    end

    // Cascade model at the falling edge; full compare just before the next rise.
    always @(negedge clk) begin
        if (!rst_n) ref_dout = 1'b0;
        else        ref_dout = mode_half ? ref_stage[N2] : ref_stage[SEGS];
        #8;
        if (running && rst_n) begin
            check("R4/R5 bank_a", bank_a, exp_bank(0));
            check("R4/R5/R9 bank_b", bank_b, exp_bank(SEGS));
            check("R3 data_out", {{(SEGS-1){1'b0}}, data_out}, {{(SEGS-1){1'b0}}, ref_dout});
            check("R8 clk_out low", {{(SEGS-1){1'b0}}, clk_out}, '0);
            check("R8 load_out", {{(SEGS-1){1'b0}}, load_out}, {{(SEGS-1){1'b0}}, load_in});
        end
    end

    // After the rising edge the cascade bit must not have moved yet (R2).
    always @(posedge clk) begin
        #5;
        if (running && rst_n) begin
            check("R2 data_out held over rise", {{(SEGS-1){1'b0}}, data_out},
                  {{(SEGS-1){1'b0}}, ref_dout});
            check("R8 clk_out high", {{(SEGS-1){1'b0}}, clk_out}, {{(SEGS-1){1'b0}}, 1'b1});
        end
    end

    // Drive one cycle's inputs, then consume one rising edge.
    task automatic step(input logic d, input logic ld);
        data_in = d;
        load_in = ld;
        @(posedge clk);
        #2;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(20 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [SEGS-1:0] saved;
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state of banks and cascade output
        check("R10 bank_a reset", bank_a, '0);
        check("R10 bank_b reset", bank_b, '0);
        check("R10 data_out reset", {{(SEGS-1){1'b0}}, data_out}, '0);
        rst_n = 1'b1;
        running = 1'b1;

        // R1: a single 1 lands in stage 1 (bank A bit 0)
        step(1'b1, 1'b1);
        check("R1 head capture", bank_a, {{(SEGS-1){1'b0}}, 1'b1});

        // R6: the first bit of a full static load reaches bank A bit SEGS-1
        for (int i = 1; i < SEGS; i++) step(1'b0, 1'b1);
        check("R6 static order", bank_a, {1'b1, {(SEGS-1){1'b0}}});

        // R7: a 1,0,1,1 pattern appears uninverted, first bit highest
        for (int i = 0; i < 4; i++) step(i != 1, 1'b1);
        check("R7 no inversion", {{(SEGS-4){1'b0}}, bank_a[3:0]}, {{(SEGS-4){1'b0}}, 4'b1011});

        // R5: strobe low, keep shifting, banks frozen
        saved = bank_a;
        for (int i = 0; i < 50; i++) step(i[0], 1'b0);
        check("R5 hold while shifting", bank_a, saved);

        // R9: static mode with transparent latch leaves bank B untouched
        saved = bank_b;
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1);
        check("R9 bank_b frozen in static", bank_b, saved);

        // R6: half-duty full load, first bit reaches bank B bit SEGS-1
        mode_half = 1'b1;
        step(1'b1, 1'b1);
        for (int i = 1; i < N2; i++) step(1'b0, 1'b1);
        check("R6 half-duty order B", bank_b, {1'b1, {(SEGS-1){1'b0}}});
        check("R6 half-duty order A", bank_a, '0);

        // Strobe edges and shifts in the same cycles, mode changes mid-burst
        for (int i = 0; i < 900; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i % 217 == 0) mode_half = ~mode_half;
            step(lfsr[0], ((i / 5) % 3 == 0) || (i % 11 == 4));
        end

        // R10: reset in mid-run clears the chain and banks
        rst_n = 1'b0;
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        check("R10 bank_a mid-run reset", bank_a, '0);
        check("R10 bank_b mid-run reset", bank_b, '0);
        @(negedge clk);
        #2;
        check("R10 data_out mid-run reset", {{(SEGS-1){1'b0}}, data_out}, '0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) step(1'b1, i < 10);

        running = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule